// File: doc/BRIEF.md
# Streaming RGB to Grayscale Converter

This block turns a stream of colour pixels into a stream of 8-bit luminance samples, one pixel per clock with no stall. Each input pixel brings red, green and blue components of 8 bits each. Alongside the pixel travels a five-signal control bundle: first pixel of a line, last pixel of a line, first pixel of a frame, last pixel of a frame, and a valid flag.

The luminance is a weighted sum of the three components. The weights are fixed-point constants scaled by 256: 77 for red, 150 for green and 29 for blue. The sum is shifted right by eight bits, so the fraction is discarded rather than rounded. The datapath has two register stages. The first registers the three products. The second registers the shifted sum. The control bundle runs through a matched two-stage delay line, so every output sample appears with the flags that entered with its pixel.

Top module: `gray_stream_conv`

## Requirements
- R1: Two clocks after a pixel is presented, `gray` equals floor((77·R + 150·G + 29·B) / 256), computed from that pixel's components.
- R2: A pixel whose three components are all equal to x produces x. This holds for x = 0 and for x = 255.
- R3: The output control bundle equals the input bundle presented two clocks earlier, and each flag keeps its meaning at the output.
- R4: The gray result appears exactly two clocks after its pixel. It does not appear one clock earlier, and it is not held for a third clock.
- R5: While `rst` is high at a clock edge, every control register is cleared. All five output flags read 0 during reset and for the first two clocks after it, even if the inputs carried set flags when reset arrived.
- R6: The pixel datapath advances on every clock whatever the value of `in_valid`. A pixel presented with valid low still produces its R1 value two clocks later.
- R7: Pixels presented on consecutive clocks produce results on consecutive clocks. Each result belongs to its own pixel, and results do not merge or repeat.
- R8: The fraction is truncated. Input (2, 0, 0) gives 154/256 and produces 0. Input (0, 0, 9) gives 261/256 and produces 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| in_line_first | input | 1 | First pixel of a line |
| in_line_last | input | 1 | Last pixel of a line |
| in_frame_first | input | 1 | First pixel of a frame |
| in_frame_last | input | 1 | Last pixel of a frame |
| in_valid | input | 1 | Pixel valid |
| gray | output | 8 | Luminance result |
| out_line_first | output | 1 | Delayed first-of-line flag |
| out_line_last | output | 1 | Delayed last-of-line flag |
| out_frame_first | output | 1 | Delayed first-of-frame flag |
| out_frame_last | output | 1 | Delayed last-of-frame flag |
| out_valid | output | 1 | Delayed valid flag |

## Verification
The bench builds the block with its default parameters: 8-bit components, 8 fraction bits, the weights 77, 150 and 29, and a control delay of two. Because these weights add up to exactly 256, the equal-component identity holds, and the full-scale inputs 0 and 255 can be checked exactly. These defaults also put the truncation cases within reach, where rounding would have given a different result. The bench streams a small frame with both back-to-back and gapped valid pixels, an isolated pixel that exposes the latency, and a reset applied in mid-stream.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    localparam int COMP_W = 8;
    localparam int FRAC_W = 8;
    localparam int NCOMP  = 3;

    localparam int WEIGHT_R = 77;
    localparam int WEIGHT_G = 150;
    localparam int WEIGHT_B = 29;

    // Sideband travelling with every pixel.
    typedef struct packed {
        logic line_first;
        logic line_last;
        logic frame_first;
        logic frame_last;
        logic valid;
    } strm_ctrl_t;

    localparam int CTRL_W = $bits(strm_ctrl_t);

    function automatic strm_ctrl_t make_ctrl(input logic lf, input logic ll,
                                             input logic ff, input logic fl,
                                             input logic v);
        strm_ctrl_t c;
        c.line_first  = lf;
        c.line_last   = ll;
        c.frame_first = ff;
        c.frame_last  = fl;
        c.valid       = v;
        return c;
    endfunction

endpackage

// File: rtl/gsc_product_stage.sv
module gsc_product_stage #(
    parameter int COMP_W = 8,
    parameter int COEF_W = 8,
    parameter int NCOMP  = 3,
    parameter logic [NCOMP-1:0][COEF_W-1:0] WEIGHTS = '0,
    localparam int PROD_W = COMP_W + COEF_W
) (
    input  logic                               clk,
    input  logic [NCOMP-1:0][COMP_W-1:0]       comp_in,
    output logic [NCOMP-1:0][PROD_W-1:0]       prod_q
);

    // One multiplier and register per component.
    for (genvar i = 0; i < NCOMP; i++) begin : g_mul
        logic [PROD_W-1:0] prod_d;
        assign prod_d = PROD_W'(comp_in[i]) * PROD_W'(WEIGHTS[i]);
        always_ff @(posedge clk) begin
            prod_q[i] <= prod_d;
        end
    end

endmodule

// File: rtl/gsc_sum_stage.sv
module gsc_sum_stage #(
    parameter int COMP_W = 8,
    parameter int FRAC_W = 8,
    parameter int NCOMP  = 3,
    localparam int PROD_W = COMP_W + FRAC_W
) (
    input  logic                         clk,
    input  logic [NCOMP-1:0][PROD_W-1:0] prod_in,
    output logic [COMP_W-1:0]            gray_q
);

    // Weights total 2**FRAC_W, so the sum stays below 2**PROD_W.
    logic [PROD_W-1:0] acc;
    logic [COMP_W-1:0] gray_d;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NCOMP; i++) begin
            acc = acc + prod_in[i];
        end
        gray_d = COMP_W'(acc >> FRAC_W);
    end

    always_ff @(posedge clk) begin
        gray_q <= gray_d;
    end

endmodule

// File: rtl/gsc_ctrl_delay.sv
module gsc_ctrl_delay
    import gsc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  strm_ctrl_t ctrl_in,
    output strm_ctrl_t ctrl_out
);

    strm_ctrl_t taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) taps[k] <= '0;
        end else begin
            taps[0] <= ctrl_in;
            for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
        end
    end

    assign ctrl_out = taps[DEPTH-1];

endmodule

// File: rtl/gray_stream_conv.sv
module gray_stream_conv
    import gsc_pkg::*;
#(
    parameter int P_COMP_W = COMP_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_WR     = WEIGHT_R,
    parameter int P_WG     = WEIGHT_G,
    parameter int P_WB     = WEIGHT_B
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_COMP_W-1:0] pix_r,
    input  logic [P_COMP_W-1:0] pix_g,
    input  logic [P_COMP_W-1:0] pix_b,
    input  logic                in_line_first,
    input  logic                in_line_last,
    input  logic                in_frame_first,
    input  logic                in_frame_last,
    input  logic                in_valid,
    output logic [P_COMP_W-1:0] gray,
    output logic                out_line_first,
    output logic                out_line_last,
    output logic                out_frame_first,
    output logic                out_frame_last,
    output logic                out_valid
);

    localparam int PROD_W   = P_COMP_W + P_FRAC_W;
    localparam int PIPE_LAT = 2;
    localparam logic [NCOMP-1:0][P_FRAC_W-1:0] WTS =
        {P_FRAC_W'(P_WB), P_FRAC_W'(P_WG), P_FRAC_W'(P_WR)};

    logic [NCOMP-1:0][P_COMP_W-1:0] comps;
    logic [NCOMP-1:0][PROD_W-1:0]   prods;
    strm_ctrl_t                     ctrl_i, ctrl_o;

    assign comps  = {pix_b, pix_g, pix_r};
    assign ctrl_i = make_ctrl(in_line_first, in_line_last,
                              in_frame_first, in_frame_last, in_valid);

    gsc_product_stage #(
        .COMP_W (P_COMP_W),
        .COEF_W (P_FRAC_W),
        .NCOMP  (NCOMP),
        .WEIGHTS(WTS)
    ) u_prod (
        .clk    (clk),
        .comp_in(comps),
        .prod_q (prods)
    );

    gsc_sum_stage #(
        .COMP_W(P_COMP_W),
        .FRAC_W(P_FRAC_W),
        .NCOMP (NCOMP)
    ) u_sum (
        .clk    (clk),
        .prod_in(prods),
        .gray_q (gray)
    );

    gsc_ctrl_delay #(
        .DEPTH(PIPE_LAT)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_i),
        .ctrl_out(ctrl_o)
    );

    assign out_line_first  = ctrl_o.line_first;
    assign out_line_last   = ctrl_o.line_last;
    assign out_frame_first = ctrl_o.frame_first;
    assign out_frame_last  = ctrl_o.frame_last;
    assign out_valid       = ctrl_o.valid;

endmodule

// File: rtl/gray_stream_conv_chk.sv
module gray_stream_conv_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] pix_r,
    input logic [7:0] pix_g,
    input logic [7:0] pix_b,
    input logic       in_line_first,
    input logic       in_line_last,
    input logic       in_frame_first,
    input logic       in_frame_last,
    input logic       in_valid,
    input logic [7:0] gray,
    input logic       out_line_first,
    input logic       out_line_last,
    input logic       out_frame_first,
    input logic       out_frame_last,
    input logic       out_valid
);

    logic [1:0] warm;
    logic [7:0] cmax, cmin;
    logic [4:0] cin, cout;
    logic       flat;

    always_ff @(posedge clk) begin
        if (rst)            warm <= 2'd0;
        else if (warm != 2) warm <= warm + 2'd1;
    end

    always_comb begin
        cmax = pix_r;
        cmin = pix_r;
        if (pix_g > cmax) cmax = pix_g;
        if (pix_b > cmax) cmax = pix_b;
        if (pix_g < cmin) cmin = pix_g;
        if (pix_b < cmin) cmin = pix_b;
        flat = (pix_r == pix_g) && (pix_g == pix_b);
        cin  = {in_line_first, in_line_last, in_frame_first, in_frame_last, in_valid};
        cout = {out_line_first, out_line_last, out_frame_first, out_frame_last, out_valid};
    end

    // R1: weighted average lies between the smallest and largest component
    p_gray_bounds_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> (gray <= $past(cmax, 2) && gray >= $past(cmin, 2)));

    // R2: equal components reproduce the component value
    p_flat_identity_r2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2 && $past(flat, 2)) |-> (gray == $past(pix_r, 2)));

    // R3: sideband delayed by two clocks
    p_ctrl_align_r3: assert property (@(posedge clk) disable iff (rst)
        (warm == 2) |-> (cout == $past(cin, 2)));

    // R5: flags are clear on the first clock after reset
    p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cout == 5'd0));

    // R5: flags still clear on the second clock after reset
    p_reset_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (warm == 1) |-> (cout == 5'd0));

endmodule

bind gray_stream_conv gray_stream_conv_chk u_chk (.*);

// File: tb/gray_stream_conv_tb.sv
module gray_stream_conv_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic [4:0] cin = '0;
    logic [7:0] gray;
    logic       o_lf, o_ll, o_ff, o_fl, o_v;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    int  seed = 12345;

    typedef struct {
        int         g;
        logic [4:0] c;
        bit         chk_gray;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    gray_stream_conv u_dut (
        .clk(clk), .rst(rst),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .in_line_first(cin[4]), .in_line_last(cin[3]),
        .in_frame_first(cin[2]), .in_frame_last(cin[1]), .in_valid(cin[0]),
        .gray(gray),
        .out_line_first(o_lf), .out_line_last(o_ll),
        .out_frame_first(o_ff), .out_frame_last(o_fl), .out_valid(o_v)
    );

    function automatic int ref_gray(input int r, input int g, input int b);
        return (77 * r + 150 * g + 29 * b) / 256;
    endfunction

    function automatic logic [4:0] cbits(input bit lf, input bit ll, input bit ff,
                                         input bit fl, input bit v);
        return {lf, ll, ff, fl, v};
    endfunction

    task automatic check_out();
        exp_t e;
        logic [4:0] act;
        if (q.size() < 2) return;
        e = q.pop_front();
        act = {o_lf, o_ll, o_ff, o_fl, o_v};
        checks++;
        if (act !== e.c) begin
            failures++;
            $display("FAIL %s ctrl actual=%b expected=%b", e.tag, act, e.c);
        end
        if (e.chk_gray) begin
            checks++;
            if (gray !== 8'(e.g)) begin
                failures++;
                $display("FAIL %s gray actual=%0d expected=%0d", e.tag, gray, e.g);
            end
        end
    endtask

    task automatic step(input int r, input int g, input int b,
                        input logic [4:0] c, input bit rs, input string tag);
        exp_t e;
        @(negedge clk);
        check_out();
        if (rs) begin
            foreach (q[i]) begin
                q[i].c = '0;
                q[i].chk_gray = 0;
                q[i].tag = "R5";
            end
        end
        rst   = rs;
        pix_r = 8'(r);
        pix_g = 8'(g);
        pix_b = 8'(b);
        cin   = c;
        e.g = ref_gray(r, g, b);
        e.c = rs ? 5'd0 : c;
        e.chk_gray = !rs;
        e.tag = rs ? "R5" : tag;
        q.push_back(e);
    endtask

    function automatic int rnd8();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset, with set flags on the inputs (R5)
        for (int i = 0; i < 4; i++) step(50, 60, 70, 5'b11111, 1, "R5");
        // First two clocks after reset: flags must still read zero (R5)
        step(1, 2, 3, 5'b00001, 0, "R5");
        step(4, 5, 6, 5'b00001, 0, "R5");

        // Equal components, including the extremes (R2)
        step(255, 255, 255, 5'b00001, 0, "R2");
        step(0, 0, 0, 5'b00001, 0, "R2");
        step(128, 128, 128, 5'b00001, 0, "R2");
        step(37, 37, 37, 5'b00001, 0, "R2");

        // Truncation (R8)
        step(2, 0, 0, 5'b00001, 0, "R8");
        step(0, 0, 9, 5'b00001, 0, "R8");
        step(0, 3, 0, 5'b00001, 0, "R8");

        // Isolated pixel between zeros (R4)
        step(0, 0, 0, 5'b00000, 0, "R4");
        step(0, 0, 0, 5'b00000, 0, "R4");
        step(200, 100, 50, 5'b00001, 0, "R4");
        step(0, 0, 0, 5'b00000, 0, "R4");
        step(0, 0, 0, 5'b00000, 0, "R4");

        // Datapath advances with valid low (R6)
        step(10, 20, 30, 5'b00000, 0, "R6");
        step(250, 1, 99, 5'b00000, 0, "R6");

        // Small frame, 3 lines x 4 pixels, with gaps (R1, R3, R7)
        for (int ln = 0; ln < 3; ln++) begin
            for (int px = 0; px < 4; px++) begin
                step(rnd8(), rnd8(), rnd8(),
                     cbits(px == 0, px == 3, ln == 0 && px == 0, ln == 2 && px == 3, 1),
                     0, ln == 1 ? "R7" : "R1");
                if (ln == 1 && px == 1) step(rnd8(), rnd8(), rnd8(), 5'b00000, 0, "R3");
            end
            step(rnd8(), rnd8(), rnd8(), 5'b00000, 0, "R3");
        end

        // Long back-to-back burst (R7)
        for (int i = 0; i < 24; i++) step(rnd8(), rnd8(), rnd8(), 5'b00001, 0, "R7");

        // Reset in mid-stream with pixels in flight (R5)
        step(90, 90, 90, 5'b11111, 0, "R3");
        step(91, 92, 93, 5'b11111, 1, "R5");
        step(91, 92, 93, 5'b11111, 1, "R5");
        step(80, 70, 60, 5'b10001, 0, "R5");
        step(80, 70, 60, 5'b01001, 0, "R5");
        step(5, 6, 7, 5'b00011, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 5'b00000, 0, "R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule